// File: doc/BRIEF.md
# Address-Match ECC Error Injector

This unit sits on the write path of a DRAM controller, between the ECC encoder and the memory. Software loads a target DRAM coordinate: row, column, bank, bank group, rank, logical rank and channel. It also loads a flip pattern and a flip control for each of the two channels. Each write arrives with its decoded coordinates, its data and its already computed check bits. When every coordinate equals the target and the unit is armed, the unit XORs the selected channel's pattern into the check bits. The memory then stores a word that reads back as a correctable or uncorrectable error. Data bits are never altered, and the unit does not compute ECC.

A pattern with one set bit (0x1) makes a correctable error. A pattern with two set bits (0x3) makes an uncorrectable one. A mode bit chooses between two behaviours. In repeating mode, every matching write is corrupted. In single-shot mode, the unit clears its own enable after the first corruption. The write path adds one register stage of latency.

Top module: `ecc_inject_match`

## Requirements
- R1: After reset, out_valid, out_hit and out_chk are zero, and every write passes through with its check bits unchanged until the unit is configured.
- R2: Configuration index 0 holds the target row in bits 17:0, column in bits 27:18, bank in bits 29:28 and bank group in bits 31:30.
- R3: Configuration index 1 holds rank in bits 1:0, logical rank in bits 4:2, channel in bit 5, mode in bit 6 and match enable in bit 8. With bit 8 clear, no write is corrupted, even when bit 7 is set.
- R4: A write whose row, column, bank, bank group, rank, logical rank or channel differs from the target leaves the unit with its check bits unchanged and out_hit low.
- R5: A matching write leaves with out_chk equal to in_chk XOR the pattern of its channel. For example, 0x1 flips bit 0 and 0x3 flips bits 1:0.
- R6: Index 2 is the channel 0 flip control and index 3 is its pattern. Index 4 is the channel 1 flip control and index 5 is its pattern. A channel corrupts a write only while its flip control reads all ones (0xFF).
- R7: A pattern of zero makes no corruption, and out_hit stays low, even on a match.
- R8: With mode = 1, every matching write is corrupted. With mode = 0, the first corruption clears match enable, so later matches pass through unchanged.
- R9: out_valid, out_data, out_chk and out_hit appear one clock after the write is presented. out_data always equals in_data.
- R10: A configuration write acts on writes presented from the next clock on. A write in the same cycle uses the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration index (0 to 5) |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Write beat present |
| in_row | input | 18 | Row of the write |
| in_col | input | 10 | Column of the write |
| in_bank | input | 2 | Bank of the write |
| in_grp | input | 2 | Bank group of the write |
| in_rank | input | 2 | Rank of the write |
| in_lrank | input | 3 | Logical rank of the write |
| in_ch | input | 1 | Channel of the write |
| in_data | input | DATA_W | Write data |
| in_chk | input | CHK_W | Check bits from the encoder |
| out_valid | output | 1 | Write beat leaving |
| out_data | output | DATA_W | Data, unchanged |
| out_chk | output | CHK_W | Check bits, possibly corrupted |
| out_hit | output | 1 | The beat leaving was corrupted |

## Verification
A wrong target field, or a field decoded from the wrong bit positions, shows up on the next beat. The unit either reports out_hit on a write that differs in a single coordinate, or misses the exact match. The bench changes one field at a time to catch this.

A lost or sticky enable shows up as a hit that does not repeat in repeating mode, or one that repeats in single-shot mode. Both appear within two writes.

A pattern or flip control taken from the wrong channel gives the wrong XOR value on the first matching beat of the other channel.

// File: rtl/ecc_inject_match.sv
module ecc_inject_match #(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8,
  parameter int CTL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              in_valid,
  input  logic [17:0]       in_row,
  input  logic [9:0]        in_col,
  input  logic [1:0]        in_bank,
  input  logic [1:0]        in_grp,
  input  logic [1:0]        in_rank,
  input  logic [2:0]        in_lrank,
  input  logic              in_ch,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CHK_W-1:0]  in_chk,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [CHK_W-1:0]  out_chk,
  output logic              out_hit
);
  localparam logic [2:0] IDX_TGT_A = 3'd0;
  localparam logic [2:0] IDX_TGT_B = 3'd1;
  localparam logic [2:0] IDX_CTL0  = 3'd2;
  localparam logic [2:0] IDX_PAT0  = 3'd3;
  localparam logic [2:0] IDX_CTL1  = 3'd4;
  localparam logic [2:0] IDX_PAT1  = 3'd5;

  logic [17:0]      t_row;
  logic [9:0]       t_col;
  logic [1:0]       t_bank;
  logic [1:0]       t_grp;
  logic [1:0]       t_rank;
  logic [2:0]       t_lrank;
  logic             t_ch;
  logic             t_mode;
  logic             t_en;
  logic [CTL_W-1:0] flip_ctl [2];
  logic [CHK_W-1:0] flip_pat [2];

  logic             coord_eq;
  logic             armed;
  logic [CHK_W-1:0] sel_pat;
  logic             inject;
  logic             unused_cfg;

  assign unused_cfg = ^cfg_wdata[31:9];

  assign coord_eq = (in_row == t_row) && (in_col == t_col) &&
                    (in_bank == t_bank) && (in_grp == t_grp) &&
                    (in_rank == t_rank) && (in_lrank == t_lrank) &&
                    (in_ch == t_ch);
  assign armed    = &flip_ctl[in_ch];
  assign sel_pat  = flip_pat[in_ch];
  assign inject   = in_valid && t_en && coord_eq && armed && (sel_pat != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_row   <= '0;
      t_col   <= '0;
      t_bank  <= '0;
      t_grp   <= '0;
      t_rank  <= '0;
      t_lrank <= '0;
      t_ch    <= 1'b0;
      t_mode  <= 1'b0;
      t_en    <= 1'b0;
      for (int i = 0; i < 2; i++) begin
        flip_ctl[i] <= '0;
        flip_pat[i] <= '0;
      end
    end else begin
      if (inject && !t_mode) t_en <= 1'b0;
      if (cfg_we) begin
        case (cfg_addr)
          IDX_TGT_A: begin
            t_row  <= cfg_wdata[17:0];
            t_col  <= cfg_wdata[27:18];
            t_bank <= cfg_wdata[29:28];
            t_grp  <= cfg_wdata[31:30];
          end
          IDX_TGT_B: begin
            t_rank  <= cfg_wdata[1:0];
            t_lrank <= cfg_wdata[4:2];
            t_ch    <= cfg_wdata[5];
            t_mode  <= cfg_wdata[6];
            t_en    <= cfg_wdata[8];
          end
          IDX_CTL0: flip_ctl[0] <= cfg_wdata[CTL_W-1:0];
          IDX_PAT0: flip_pat[0] <= cfg_wdata[CHK_W-1:0];
          IDX_CTL1: flip_ctl[1] <= cfg_wdata[CTL_W-1:0];
          IDX_PAT1: flip_pat[1] <= cfg_wdata[CHK_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_chk   <= '0;
      out_hit   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_data  <= in_data;
      out_chk   <= in_chk ^ (inject ? sel_pat : '0);
      out_hit   <= inject;
    end
  end

  assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_hit));
  assert_data_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_data == $past(in_data)));
  assert_hit_alters_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> (out_chk != $past(in_chk)));
  assert_clean_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_chk == $past(in_chk)));
  assert_disabled_no_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !t_en) |=> !out_hit);
  assert_single_shot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inject && !t_mode && !(cfg_we && cfg_addr == IDX_TGT_B)) |=> !t_en);
endmodule

// File: tb/ecc_inject_match_bench.sv
module ecc_inject_match_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        in_valid;
  logic [17:0] in_row;
  logic [9:0]  in_col;
  logic [1:0]  in_bank, in_grp, in_rank;
  logic [2:0]  in_lrank;
  logic        in_ch;
  logic [63:0] in_data;
  logic [7:0]  in_chk;
  logic        out_valid, out_hit;
  logic [63:0] out_data;
  logic [7:0]  out_chk;

  always #10 clk = ~clk;

  ecc_inject_match u_ecc_inject_match (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_row(in_row),
    .in_col(in_col), .in_bank(in_bank), .in_grp(in_grp), .in_rank(in_rank),
    .in_lrank(in_lrank), .in_ch(in_ch), .in_data(in_data), .in_chk(in_chk),
    .out_valid(out_valid), .out_data(out_data), .out_chk(out_chk),
    .out_hit(out_hit));

  localparam logic [17:0] TR = 18'h2A5C3;
  localparam logic [9:0]  TC = 10'h1B7;
  localparam logic [1:0]  TB = 2'd2;
  localparam logic [1:0]  TG = 2'd1;
  localparam logic [1:0]  TK = 2'd1;
  localparam logic [2:0]  TL = 3'd5;

  int  n_run = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;
  logic [72:0] expq[$];
  string       tagq[$];

  function automatic logic [31:0] reg_a(logic [17:0] r, logic [9:0] c, logic [1:0] b, logic [1:0] g);
    return {g, b, c, r};
  endfunction

  function automatic logic [31:0] reg_b(logic [1:0] k, logic [2:0] l, bit ch, bit mode, bit en);
    return {23'd0, en, 1'b0, mode, ch, l, k};
  endfunction

  task automatic check(bit ok, string tag, logic [72:0] act, logic [72:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg(logic [2:0] a, logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(logic [17:0] r, logic [9:0] c, logic [1:0] b, logic [1:0] g,
                      logic [1:0] k, logic [2:0] l, bit ch, logic [63:0] d,
                      logic [7:0] chk, logic [7:0] exp_chk, bit exp_hit, string tag);
    in_valid = 1'b1; in_row = r; in_col = c; in_bank = b; in_grp = g;
    in_rank = k; in_lrank = l; in_ch = ch; in_data = d; in_chk = chk;
    expq.push_back({exp_hit, exp_chk, d});
    tagq.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (expq.size() == 0) begin
        check(1'b0, "R9 unexpected beat", {out_hit, out_chk, out_data}, '0);
      end else begin
        logic [72:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check({out_hit, out_chk, out_data} === e, t, {out_hit, out_chk, out_data}, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL R9 watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_row = '0; in_col = '0; in_bank = '0; in_grp = '0;
    in_rank = '0; in_lrank = '0; in_ch = 1'b0; in_data = '0; in_chk = '0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 reset valid", {72'd0, out_valid}, '0);
    check(out_hit === 1'b0, "R1 reset hit", {72'd0, out_hit}, '0);
    check(out_chk === 8'h00, "R1 reset chk", {65'd0, out_chk}, '0);
    rst_n = 1'b1;

    send(TR, TC, TB, TG, TK, TL, 1'b1, 64'h0123_4567_89AB_CDEF, 8'hA5, 8'hA5, 1'b0, "R1 unconfigured pass");

    cfg(3'd0, reg_a(TR, TC, TB, TG));
    cfg(3'd1, reg_b(TK, TL, 1'b1, 1'b1, 1'b1));
    cfg(3'd4, 32'h0000_00FF);
    cfg(3'd5, 32'h0000_0001);
    cfg(3'd3, 32'h0000_0003);
    cfg(3'd2, 32'h0000_0000);

    send(TR, TC, TB, TG, TK, TL, 1'b1, 64'hDEAD_BEEF_0000_0001, 8'hA5, 8'hA4, 1'b1, "R2 R5 match ch1 single flip");
    send(TR, TC, TB, TG, TK, TL, 1'b1, 64'hDEAD_BEEF_0000_0002, 8'h3C, 8'h3D, 1'b1, "R8 repeating mode again");
    send(TR ^ 18'h1, TC, TB, TG, TK, TL, 1'b1, 64'h11, 8'h3C, 8'h3C, 1'b0, "R4 row differs");
    send(TR, TC ^ 10'h200, TB, TG, TK, TL, 1'b1, 64'h12, 8'h3C, 8'h3C, 1'b0, "R4 column differs");
    send(TR, TC, TB ^ 2'h1, TG, TK, TL, 1'b1, 64'h13, 8'h3C, 8'h3C, 1'b0, "R4 bank differs");
    send(TR, TC, TB, TG ^ 2'h2, TK, TL, 1'b1, 64'h14, 8'h3C, 8'h3C, 1'b0, "R4 group differs");
    send(TR, TC, TB, TG, TK ^ 2'h1, TL, 1'b1, 64'h15, 8'h3C, 8'h3C, 1'b0, "R4 rank differs");
    send(TR, TC, TB, TG, TK, TL ^ 3'h4, 1'b1, 64'h16, 8'h3C, 8'h3C, 1'b0, "R4 logical rank differs");
    send(TR, TC, TB, TG, TK, TL, 1'b0, 64'h17, 8'h3C, 8'h3C, 1'b0, "R4 channel differs");

    cfg(3'd1, reg_b(TK, TL, 1'b0, 1'b1, 1'b1));
    send(TR, TC, TB, TG, TK, TL, 1'b0, 64'h20, 8'h5A, 8'h5A, 1'b0, "R6 channel 0 control not armed");
    cfg(3'd2, 32'h0000_00FF);
    send(TR, TC, TB, TG, TK, TL, 1'b0, 64'h21, 8'h5A, 8'h59, 1'b1, "R5 R6 channel 0 double flip");

    cfg_we = 1'b1; cfg_addr = 3'd3; cfg_wdata = 32'h1;
    send(TR, TC, TB, TG, TK, TL, 1'b0, 64'h22, 8'h0F, 8'h0C, 1'b1, "R10 same-cycle uses old pattern");
    cfg_we = 1'b0;
    send(TR, TC, TB, TG, TK, TL, 1'b0, 64'h23, 8'h0F, 8'h0E, 1'b1, "R10 new pattern next write");

    cfg(3'd3, 32'h0);
    send(TR, TC, TB, TG, TK, TL, 1'b0, 64'h24, 8'h77, 8'h77, 1'b0, "R7 zero pattern no flip");

    cfg(3'd3, 32'h3);
    cfg(3'd1, reg_b(TK, TL, 1'b0, 1'b1, 1'b0));
    send(TR, TC, TB, TG, TK, TL, 1'b0, 64'h25, 8'h77, 8'h77, 1'b0, "R3 enable clear");
    cfg(3'd1, reg_b(TK, TL, 1'b0, 1'b1, 1'b0) | 32'h80);
    send(TR, TC, TB, TG, TK, TL, 1'b0, 64'h26, 8'h77, 8'h77, 1'b0, "R3 bit 7 is not enable");

    cfg(3'd1, reg_b(TK, TL, 1'b0, 1'b0, 1'b1));
    send(TR, TC, TB, TG, TK, TL, 1'b0, 64'h27, 8'h11, 8'h12, 1'b1, "R8 single-shot first");
    send(TR, TC, TB, TG, TK, TL, 1'b0, 64'h28, 8'h11, 8'h11, 1'b0, "R8 single-shot second");

    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R9 all beats returned", 73'(expq.size()), '0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    finished = 1'b1;
    $finish;
  end
endmodule